// File: doc/BRIEF.md
# Three-wire serial configuration memory, read-only responder

This block stands in for a small three-wire serial configuration memory that firmware drives one bit at a time through a single control/status register. Every register write carries the select line, the serial clock and the host-to-memory data bit. A register read returns that same value, except that one bit is replaced by the data bit the memory is currently presenting. A read transaction is a start bit, a two-bit command and a six-bit word address. After it, the memory presents 16-bit words most significant bit first, one bit per clock rising edge. It moves to the next word by itself, so a single transaction can stream any number of words until the select line drops.

The contents are fixed when the block is built. A parameterised 48-bit station identifier occupies three consecutive words starting at a parameterised base word, and every other word reads as zero. Only the read command is answered; any other command code sends the protocol back to waiting for a start bit.

Top module: `srom_read_responder`

## Requirements
- R1: After reset the register reads back as all zeros and the protocol waits for a start bit.
- R2: A register read returns bits 3, 1 and 0 of the last written value. Bit 2 is always the memory's current output bit, whatever value was written there.
- R3: A bit is exchanged only on a write that has select (bit 0) high and the clock (bit 1) high when the previous write had the clock low. Any other write leaves the output bit and the protocol position unchanged.
- R4: A write with select low returns the protocol to waiting for a start bit and discards the partial command, the address and the bit position. A later read must begin with a fresh start bit.
- R5: While waiting for a start bit, received zeros are ignored. The first received one begins command collection.
- R6: The two command bits arrive most significant first. Only binary 10 (read) is accepted. Any other code returns the protocol to waiting for a start bit, and the output bit does not change.
- R7: After a read command, six address bits are taken in most significant first (host data is bit 3). The first data bit appears on the rising edge that follows the last address bit, and the bits of each word go out from bit 15 down to bit 0.
- R8: After bit 0 of a word is presented, the address advances by one. The next rising edge presents bit 15 of the following word.
- R9: Only the low four address bits select a word. Addresses 16 to 63 alias onto words 0 to 15, and the word after word 15 is word 0.
- R10: The three words from the base word (10 by default) hold the 48-bit station identifier, high word first. All other words read as zero.
- R11: The output bit is 0 after reset. It holds its value between rising edges and across a select-low write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_data | input | 4 | Write value: bit 0 select, bit 1 serial clock, bit 3 host data; bit 2 ignored |
| rd_data | output | 4 | Read value: last written bits with bit 2 replaced by the memory output bit |

## Verification
The assertions check on every cycle that written bits read back unchanged and that the output bit changes only on a qualifying select-and-rising-clock write. They also check that the output is frozen when no write occurs, that a select-low write always leaves the sequencer idle, and that the word bit counter stays inside its range during data transfer. Only the bench scenarios can show the protocol content itself. That content covers start-bit filtering, rejection of non-read command codes, and the exact 48-bit identifier returned across three words. It also covers automatic advance and wrap from word 15 to word 0, aliasing of high addresses, and a clean restart after a transaction is cut short.

// File: rtl/srom_pkg.sv
package srom_pkg;

    // Register bit layout shared by the register port, the checker and the bench
    localparam int CSR_W  = 4;
    localparam int SEL_B  = 0;   // select
    localparam int CLK_B  = 1;   // serial clock
    localparam int DIN_B  = 2;   // memory-to-host data
    localparam int DOUT_B = 3;   // host-to-memory data

    localparam logic [1:0] OP_READ = 2'b10;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_OPCODE,
        PH_ADDR,
        PH_DATA
    } phase_t;

    // One decoded register write as seen by the sequencer
    typedef struct packed {
        logic strobe;    // qualified rising edge with select high
        logic deselect;  // write with select low
        logic bit_in;    // host data bit of the write
    } step_t;

endpackage

// File: rtl/srom_csr_port.sv
module srom_csr_port
    import srom_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [CSR_W-1:0] wr_data,
    input  logic             mem_bit,
    output step_t            step,
    output logic [CSR_W-1:0] rd_data
);

    logic [CSR_W-1:0] csr_q;

    always_ff @(posedge clk) begin
        if (rst)
            csr_q <= '0;
        else if (wr_en)
            csr_q <= wr_data;
    end

    // The edge is measured against the previously written clock bit
    always_comb begin
        step.strobe   = wr_en & wr_data[SEL_B] & wr_data[CLK_B] & ~csr_q[CLK_B];
        step.deselect = wr_en & ~wr_data[SEL_B];
        step.bit_in   = wr_data[DOUT_B];
    end

    always_comb begin
        rd_data        = csr_q;
        rd_data[DIN_B] = mem_bit;
    end

endmodule

// File: rtl/srom_seq.sv
module srom_seq
    import srom_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int WORD_W = 16,
    parameter int IDX_W  = 4,
    parameter int CNT_W  = $clog2(WORD_W + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  step_t             step,
    input  logic [WORD_W-1:0] word,
    output phase_t            phase,
    output logic [CNT_W-1:0]  cnt,
    output logic [IDX_W-1:0]  rd_idx,
    output logic              mem_bit
);

    localparam int POS_W = $clog2(WORD_W);

    phase_t            phase_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              op_hi_q;
    logic [ADDR_W-1:0] addr_q;
    logic              out_q;
    logic [POS_W-1:0]  pos;

    assign pos = POS_W'(cnt_q - CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst || step.deselect) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            op_hi_q <= 1'b0;
            addr_q  <= '0;
            if (rst)
                out_q <= 1'b0;
        end else if (step.strobe) begin
            unique case (phase_q)
                PH_IDLE: begin
                    if (step.bit_in)
                        phase_q <= PH_OPCODE;
                end
                PH_OPCODE: begin
                    op_hi_q <= step.bit_in;
                    if (cnt_q == CNT_W'(1)) begin
                        cnt_q   <= '0;
                        op_hi_q <= 1'b0;
                        if ({op_hi_q, step.bit_in} == OP_READ)
                            phase_q <= PH_ADDR;
                        else
                            phase_q <= PH_IDLE;
                    end else begin
                        cnt_q <= cnt_q + CNT_W'(1);
                    end
                end
                PH_ADDR: begin
                    addr_q <= {addr_q[ADDR_W-2:0], step.bit_in};
                    if (cnt_q == CNT_W'(ADDR_W - 1)) begin
                        cnt_q   <= CNT_W'(WORD_W);
                        phase_q <= PH_DATA;
                    end else begin
                        cnt_q <= cnt_q + CNT_W'(1);
                    end
                end
                PH_DATA: begin
                    out_q <= word[pos];
                    if (cnt_q == CNT_W'(1)) begin
                        cnt_q  <= CNT_W'(WORD_W);
                        addr_q <= addr_q + ADDR_W'(1);
                    end else begin
                        cnt_q <= cnt_q - CNT_W'(1);
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign phase   = phase_q;
    assign cnt     = cnt_q;
    assign rd_idx  = addr_q[IDX_W-1:0];
    assign mem_bit = out_q;

endmodule

// File: rtl/srom_rom.sv
module srom_rom #(
    parameter int                 WORD_W    = 16,
    parameter int                 DEPTH     = 16,
    parameter int                 IDX_W     = $clog2(DEPTH),
    parameter int                 BASE_WORD = 10,
    parameter int                 IMG_W     = 48,
    parameter logic [IMG_W-1:0]   IMG       = '0
) (
    input  logic [IDX_W-1:0]  idx,
    output logic [WORD_W-1:0] word
);

    localparam int N_IMG = IMG_W / WORD_W;

    logic [WORD_W-1:0] mem [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        if (g >= BASE_WORD && g < BASE_WORD + N_IMG) begin : g_img
            assign mem[g] = IMG[IMG_W-1-(g-BASE_WORD)*WORD_W -: WORD_W];
        end else begin : g_zero
            assign mem[g] = '0;
        end
    end

    assign word = mem[idx];

endmodule

// File: rtl/srom_read_responder.sv
module srom_read_responder
    import srom_pkg::*;
#(
    parameter int          ADDR_W    = 6,
    parameter int          WORD_W    = 16,
    parameter int          DEPTH     = 16,
    parameter int          BASE_WORD = 10,
    parameter int          STATION_W = 48,
    parameter logic [47:0] STATION   = 48'h02A0_5C11_E7D3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [CSR_W-1:0] wr_data,
    output logic [CSR_W-1:0] rd_data
);

    localparam int IDX_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(WORD_W + 1);

    step_t             step;
    logic              mem_bit;
    logic [WORD_W-1:0] word;
    logic [IDX_W-1:0]  rd_idx;
    phase_t            phase_w;
    logic [CNT_W-1:0]  cnt_w;

    srom_csr_port u_port (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .mem_bit (mem_bit),
        .step    (step),
        .rd_data (rd_data)
    );

    srom_seq #(
        .ADDR_W (ADDR_W),
        .WORD_W (WORD_W),
        .IDX_W  (IDX_W),
        .CNT_W  (CNT_W)
    ) u_seq (
        .clk     (clk),
        .rst     (rst),
        .step    (step),
        .word    (word),
        .phase   (phase_w),
        .cnt     (cnt_w),
        .rd_idx  (rd_idx),
        .mem_bit (mem_bit)
    );

    srom_rom #(
        .WORD_W    (WORD_W),
        .DEPTH     (DEPTH),
        .IDX_W     (IDX_W),
        .BASE_WORD (BASE_WORD),
        .IMG_W     (STATION_W),
        .IMG       (STATION[STATION_W-1:0])
    ) u_rom (
        .idx  (rd_idx),
        .word (word)
    );

endmodule

// File: rtl/srom_read_responder_chk.sv
module srom_read_responder_chk
    import srom_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int CNT_W  = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic             wr_sel,
    input logic             wr_clk,
    input logic             wr_dout,
    input logic [CSR_W-1:0] rd_data,
    input phase_t           phase,
    input logic [CNT_W-1:0] cnt
);

    // R1, R11: reset clears the register image and the output bit
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (rd_data == '0));

    // R2: written bits come back unchanged
    a_r2_readback: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (rd_data[DOUT_B] == $past(wr_dout) &&
                   rd_data[CLK_B]  == $past(wr_clk)  &&
                   rd_data[SEL_B]  == $past(wr_sel)));

    // R3: without a qualifying rising clock write the output bit is unchanged
    a_r3_edge_only: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !(wr_sel && wr_clk && !rd_data[CLK_B])) |=> $stable(rd_data[DIN_B]));

    // R11: nothing changes between writes
    a_r11_hold: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(rd_data));

    // R4: a select-low write leaves the sequencer waiting for a start bit
    a_r4_deselect_idle: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_sel) |=> (phase == PH_IDLE));

    // R7: the word bit counter stays inside 1..WORD_W while streaming
    a_r7_count_range: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_DATA) |-> (cnt >= CNT_W'(1) && cnt <= CNT_W'(WORD_W)));

endmodule

bind srom_read_responder srom_read_responder_chk #(
    .WORD_W (WORD_W),
    .CNT_W  (CNT_W)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_sel  (wr_data[srom_pkg::SEL_B]),
    .wr_clk  (wr_data[srom_pkg::CLK_B]),
    .wr_dout (wr_data[srom_pkg::DOUT_B]),
    .rd_data (rd_data),
    .phase   (phase_w),
    .cnt     (cnt_w)
);

// File: tb/tb_srom_read_responder.sv
`timescale 1ns/1ps
module tb_srom_read_responder;

    localparam logic [47:0] STATION = 48'h02A0_5C11_E7D3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [3:0] wr_data = 4'b0;
    logic [3:0] rd_data;

    always #2 clk = ~clk;   // 250 MHz

    srom_read_responder #(.STATION(STATION)) dut (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_data (rd_data)
    );

    typedef struct {
        logic [3:0] exp;
        string      tag;
    } item_t;

    item_t sb[$];
    int    checks = 0;
    int    errors = 0;
    logic  exp_valid = 1'b0;
    logic  due = 1'b0;
    logic  model_out = 1'b0;   // expected memory output bit

    function automatic void check(string tag, logic [3:0] act, logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: rd_data actual %b expected %b", tag, act, exp);
        end
    endfunction

    // Monitor: one result per write, valid at the negedge after the write edge
    always @(posedge clk) due <= wr_en && exp_valid;

    always @(negedge clk) begin
        item_t it;
        if (due) begin
            if (sb.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL R2: result with no expectation, actual %b expected none", rd_data);
            end else begin
                it = sb.pop_front();
                check(it.tag, rd_data, it.exp);
            end
        end
    end

    // R10: station identifier in words 10..12, high word first
    function automatic logic [15:0] ref_word(int idx);
        case (idx % 16)
            10:      return STATION[47:32];
            11:      return STATION[31:16];
            12:      return STATION[15:0];
            default: return 16'h0000;
        endcase
    endfunction

    // Driver: one register write, expectation pushed to the scoreboard
    task automatic wr(input logic [3:0] v, input string tag);
        @(negedge clk);
        wr_en     = 1'b1;
        wr_data   = v;
        exp_valid = 1'b1;
        sb.push_back('{exp: {v[3], model_out, v[1:0]}, tag: tag});
        @(negedge clk);
        wr_en     = 1'b0;
        exp_valid = 1'b0;
    endtask

    task automatic clk_bit(input logic b, input string tag,
                           input logic data_ph, input logic nb);
        wr({b, 1'b0, 1'b0, 1'b1}, tag);
        if (data_ph) model_out = nb;
        wr({b, 1'b0, 1'b1, 1'b1}, tag);
    endtask

    task automatic deselect(input string tag);
        wr(4'b0000, tag);
    endtask

    task automatic send_hdr(input logic [1:0] op, input logic [5:0] a, input string tag);
        clk_bit(1'b1, tag, 1'b0, 1'b0);
        clk_bit(op[1], tag, 1'b0, 1'b0);
        clk_bit(op[0], tag, 1'b0, 1'b0);
        if (op == 2'b10)
            for (int i = 5; i >= 0; i--) clk_bit(a[i], tag, 1'b0, 1'b0);
    endtask

    // Stream nbits starting at bit offset 'first' of word 'start'
    task automatic stream(input int start, input int first, input int nbits, input string tag);
        for (int k = first; k < first + nbits; k++) begin
            logic [15:0] w;
            w = ref_word(start + k / 16);
            clk_bit(1'b0, tag, 1'b1, w[15 - (k % 16)]);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1", rd_data, 4'b0000);

        // R2: readback with bit 2 replaced by the output bit
        wr(4'b1010, "R2");
        wr(4'b0100, "R2");
        wr(4'b1001, "R2");
        deselect("R2");

        // R7 R8 R10: full read of words 10..12
        send_hdr(2'b10, 6'd10, "R7");
        stream(10, 0, 48, "R8 R10");
        deselect("R10");

        // R5: leading zeros are ignored
        for (int i = 0; i < 3; i++) clk_bit(1'b0, "R5", 1'b0, 1'b0);
        send_hdr(2'b10, 6'd12, "R5");
        stream(12, 0, 16, "R5");
        deselect("R5");

        // R6: non-read codes are rejected and the output bit holds
        send_hdr(2'b11, 6'd0, "R6");
        send_hdr(2'b01, 6'd0, "R6");
        send_hdr(2'b10, 6'd11, "R6");
        stream(11, 0, 16, "R6");
        deselect("R6");

        // R9: high address aliases, and wrap from word 15 to word 0
        send_hdr(2'b10, 6'd44, "R9");
        stream(12, 0, 16, "R9");
        deselect("R9");
        send_hdr(2'b10, 6'd15, "R9");
        stream(15, 0, 16 * 12, "R9");
        deselect("R9");

        // R3: repeated high-clock writes do not advance
        send_hdr(2'b10, 6'd10, "R3");
        stream(10, 0, 4, "R3");
        wr(4'b1011, "R3");
        wr(4'b0011, "R3");
        wr(4'b0001, "R3");
        wr(4'b0001, "R3");
        stream(10, 4, 12, "R3");
        deselect("R3");

        // R4 R11: cut a read short, output bit holds, fresh read restarts cleanly
        send_hdr(2'b10, 6'd10, "R4");
        stream(10, 0, 5, "R4");
        deselect("R11");
        repeat (5) @(negedge clk);
        check("R11", rd_data, {1'b0, model_out, 2'b00});
        send_hdr(2'b10, 6'd12, "R4");
        stream(12, 0, 16, "R4");
        deselect("R4");

        repeat (4) @(negedge clk);
        if (sb.size() != 0) begin
            checks++;
            errors++;
            $display("FAIL R2: %0d results missing, actual 0 expected %0d", sb.size(), sb.size());
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 150000);
        checks++;
        errors++;
        $display("FAIL R1: watchdog expired, actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule